// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block supplies the raster timing for a character-based display controller. A horizontal position counter moves forward by eight pixel clocks on every enabled cycle and wraps at a programmable line length. A vertical line counter counts lines and wraps at the end of each field. Each time the field wraps, a field flag toggles, so even and odd interlace fields alternate. With the default settings a field has 312 lines. Each line has 128 steps of eight pixels, and 80 of those steps (640 pixels) form the visible part.

On a chosen line, once per field, the generator produces a real-time-clock interrupt. In the even field the interrupt comes at the start of that line. In the odd field it comes at the half-line position. The block also tracks which scanline of a character row is being drawn. At the start of each frame it loads the row and byte address registers from a screen base input. Every event is decoded from the position held before the counters advance in that cycle. The counters are updated last.

Top module: `raster_timer`

## Requirements
- R1: When `step_en` is high at a clock edge, `h_pos` increases by 8. When `h_pos` is at H_TOTAL-8, it returns to 0 instead. When `step_en` is low, `h_pos`, `v_pos`, `field_odd` and `char_row` all keep their values.
- R2: When `h_pos` wraps, `v_pos` increments. If `v_pos` was V_LAST when `h_pos` wrapped, `v_pos` returns to 0 and `field_odd` inverts.
- R3: Events are decoded from the position held before the enabled edge. An event whose decode position is the state after N enabled edges shows its effect after edge N+1.
- R4: `rtc_pulse` is high for exactly one cycle, once per field. It fires after the enabled edge taken from line RTC_LINE. In the even field (`field_odd`=0) that edge is at `h_pos`=0. In the odd field (`field_odd`=1) it is at `h_pos`=H_HALF.
- R5: `rtc_flag` sets on the same edge as `rtc_pulse`. It stays set until `irq_clr` is sampled high. If a set and a clear happen on the same edge, the set wins.
- R6: `char_row` changes only on an enabled edge taken at `h_pos`=HSYNC_END. On that edge it goes to 0 if `v_pos` is V_LAST or if `char_row` equals `row_last`. Otherwise it increments by 1.
- R7: On an enabled edge taken at `h_pos`=H_ADDR_LOAD with `v_pos`=V_LAST, `row_addr` and `byte_addr` both load `base_addr`. At all other times they hold their values.
- R8: A synchronous `rst` sets `h_pos`, `v_pos`, `field_odd`, `char_row`, `rtc_pulse` and `rtc_flag` to 0. It loads `row_addr` and `byte_addr` from `base_addr`.
- R9: With the default settings, one field takes 312 × 128 = 39936 enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Enables one raster step |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| base_addr | input | ADDR_W | Screen start address |
| row_last | input | ROW_W | Index of the last scanline in a character row |
| h_pos | output | HW | Horizontal position in pixels |
| v_pos | output | VW | Line within the field |
| field_odd | output | 1 | Interlace field flag |
| char_row | output | ROW_W | Scanline within the current character row |
| row_addr | output | ADDR_W | Row start address register |
| byte_addr | output | ADDR_W | Byte address register |
| rtc_pulse | output | 1 | One-cycle interrupt pulse |
| rtc_flag | output | 1 | Sticky interrupt status |

## Verification
Every output is a register that changes at the enabled edge which consumes a position. Because of this, each result is due exactly one edge after the cycle whose pre-advance position triggers it. A stalled cycle produces no result at all. The bench counts enabled edges and derives the expected counters, character row and address values from that count in closed form. It samples 5 ns after each rising edge. The expected interrupt arrivals are queued as edge counts and popped as pulses appear. One stall is placed exactly on the even-field match position, to show that the pulse waits for the next enabled edge.

// File: rtl/raster_pkg.sv
package raster_pkg;
   localparam int unsigned PIX_STEP = 8;

   typedef enum logic {
      FIELD_EVEN = 1'b0,
      FIELD_ODD  = 1'b1
   } field_e;
endpackage

// File: rtl/raster_pos_ctr.sv
module raster_pos_ctr
   import raster_pkg::*;
#(
   parameter int H_TOTAL = 1024,
   parameter int V_LAST  = 311,
   parameter int HW      = 10,
   parameter int VW      = 9
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step_en,
   output logic [HW-1:0] h_pos,
   output logic [VW-1:0] v_pos,
   output logic          field_odd
);
   localparam logic [HW-1:0] H_LAST_C = HW'(H_TOTAL - int'(PIX_STEP));
   localparam logic [VW-1:0] V_LAST_C = VW'(V_LAST);

   field_e fld;

   always_ff @(posedge clk) begin
      if (rst) begin
         h_pos <= '0;
         v_pos <= '0;
         fld   <= FIELD_EVEN;
      end else if (step_en) begin
         if (h_pos == H_LAST_C) begin
            h_pos <= '0;
            if (v_pos == V_LAST_C) begin
               v_pos <= '0;
               fld   <= (fld == FIELD_EVEN) ? FIELD_ODD : FIELD_EVEN;
            end else begin
               v_pos <= v_pos + 1'b1;
            end
         end else begin
            h_pos <= h_pos + HW'(PIX_STEP);
         end
      end
   end

   assign field_odd = (fld == FIELD_ODD);
endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen #(
   parameter int RTC_LINE   = 100,
   parameter int H_HALF     = 512,
   parameter int HW         = 10,
   parameter int VW         = 9,
   parameter bit IRQ_STICKY = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step_en,
   input  logic          irq_clr,
   input  logic [HW-1:0] h_pos,
   input  logic [VW-1:0] v_pos,
   input  logic          field_odd,
   output logic          rtc_pulse,
   output logic          rtc_flag
);
   localparam logic [VW-1:0] RTC_C  = VW'(RTC_LINE);
   localparam logic [HW-1:0] HALF_C = HW'(H_HALF);

   logic on_line;
   logic at_point;
   logic fire;

   always_comb begin
      on_line  = (v_pos == RTC_C);
      at_point = field_odd ? (h_pos == HALF_C) : (h_pos == '0);
      fire     = step_en && on_line && at_point;
   end

   always_ff @(posedge clk) begin
      if (rst) rtc_pulse <= 1'b0;
      else     rtc_pulse <= fire;
   end

   generate
      if (IRQ_STICKY) begin : g_sticky
         always_ff @(posedge clk) begin
            if (rst)          rtc_flag <= 1'b0;
            else if (fire)    rtc_flag <= 1'b1;
            else if (irq_clr) rtc_flag <= 1'b0;
         end
      end else begin : g_no_sticky
         always_comb rtc_flag = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/row_addr_track.sv
module row_addr_track #(
   parameter int HSYNC_END   = 832,
   parameter int H_ADDR_LOAD = 896,
   parameter int V_LAST      = 311,
   parameter int HW          = 10,
   parameter int VW          = 9,
   parameter int ROW_W       = 4,
   parameter int ADDR_W      = 15
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_en,
   input  logic [HW-1:0]     h_pos,
   input  logic [VW-1:0]     v_pos,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [ROW_W-1:0]  row_last,
   output logic [ROW_W-1:0]  char_row,
   output logic [ADDR_W-1:0] row_addr,
   output logic [ADDR_W-1:0] byte_addr
);
   localparam logic [HW-1:0] SYNC_END_C = HW'(HSYNC_END);
   localparam logic [HW-1:0] LOAD_C     = HW'(H_ADDR_LOAD);
   localparam logic [VW-1:0] V_LAST_C   = VW'(V_LAST);

   logic on_last_line;
   logic row_tick;
   logic addr_tick;

   always_comb begin
      on_last_line = (v_pos == V_LAST_C);
      row_tick     = step_en && (h_pos == SYNC_END_C);
      addr_tick    = step_en && (h_pos == LOAD_C) && on_last_line;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         char_row <= '0;
      end else if (row_tick) begin
         if (on_last_line || (char_row == row_last)) char_row <= '0;
         else                                        char_row <= char_row + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst || addr_tick) begin
         row_addr  <= base_addr;
         byte_addr <= base_addr;
      end
   end
endmodule

// File: rtl/raster_timer.sv
module raster_timer
   import raster_pkg::*;
#(
   parameter int H_TOTAL     = 1024,
   parameter int H_HALF      = 512,
   parameter int HSYNC_END   = 832,
   parameter int H_ADDR_LOAD = 896,
   parameter int V_LAST      = 311,
   parameter int RTC_LINE    = 100,
   parameter int ADDR_W      = 15,
   parameter int ROW_W       = 4,
   parameter bit IRQ_STICKY  = 1'b1,
   localparam int HW         = $clog2(H_TOTAL),
   localparam int VW         = $clog2(V_LAST + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_en,
   input  logic              irq_clr,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [ROW_W-1:0]  row_last,
   output logic [HW-1:0]     h_pos,
   output logic [VW-1:0]     v_pos,
   output logic              field_odd,
   output logic [ROW_W-1:0]  char_row,
   output logic [ADDR_W-1:0] row_addr,
   output logic [ADDR_W-1:0] byte_addr,
   output logic              rtc_pulse,
   output logic              rtc_flag
);
   generate
      if (H_TOTAL % int'(PIX_STEP) != 0) begin : g_bad_total
         $error("raster_timer: H_TOTAL must be a multiple of the step");
      end
      if (H_HALF % int'(PIX_STEP) != 0 || H_HALF >= H_TOTAL) begin : g_bad_half
         $error("raster_timer: H_HALF must be a step inside the line");
      end
      if (HSYNC_END % int'(PIX_STEP) != 0 || HSYNC_END >= H_TOTAL) begin : g_bad_sync
         $error("raster_timer: HSYNC_END must be a step inside the line");
      end
      if (H_ADDR_LOAD % int'(PIX_STEP) != 0 || H_ADDR_LOAD >= H_TOTAL) begin : g_bad_load
         $error("raster_timer: H_ADDR_LOAD must be a step inside the line");
      end
      if (RTC_LINE > V_LAST) begin : g_bad_rtc
         $error("raster_timer: RTC_LINE beyond the field");
      end
   endgenerate

   raster_pos_ctr #(
      .H_TOTAL(H_TOTAL), .V_LAST(V_LAST), .HW(HW), .VW(VW)
   ) u_pos (
      .clk(clk), .rst(rst), .step_en(step_en),
      .h_pos(h_pos), .v_pos(v_pos), .field_odd(field_odd)
   );

   rtc_irq_gen #(
      .RTC_LINE(RTC_LINE), .H_HALF(H_HALF), .HW(HW), .VW(VW),
      .IRQ_STICKY(IRQ_STICKY)
   ) u_irq (
      .clk(clk), .rst(rst), .step_en(step_en), .irq_clr(irq_clr),
      .h_pos(h_pos), .v_pos(v_pos), .field_odd(field_odd),
      .rtc_pulse(rtc_pulse), .rtc_flag(rtc_flag)
   );

   row_addr_track #(
      .HSYNC_END(HSYNC_END), .H_ADDR_LOAD(H_ADDR_LOAD), .V_LAST(V_LAST),
      .HW(HW), .VW(VW), .ROW_W(ROW_W), .ADDR_W(ADDR_W)
   ) u_row (
      .clk(clk), .rst(rst), .step_en(step_en),
      .h_pos(h_pos), .v_pos(v_pos),
      .base_addr(base_addr), .row_last(row_last),
      .char_row(char_row), .row_addr(row_addr), .byte_addr(byte_addr)
   );
endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk #(
   parameter int H_TOTAL     = 1024,
   parameter int H_HALF      = 512,
   parameter int HSYNC_END   = 832,
   parameter int H_ADDR_LOAD = 896,
   parameter int V_LAST      = 311,
   parameter int RTC_LINE    = 100,
   parameter int ADDR_W      = 15,
   parameter int ROW_W       = 4,
   parameter bit IRQ_STICKY  = 1'b1,
   parameter int HW          = 10,
   parameter int VW          = 9
) (
   input logic              clk,
   input logic              rst,
   input logic              step_en,
   input logic              irq_clr,
   input logic [ADDR_W-1:0] base_addr,
   input logic [ROW_W-1:0]  row_last,
   input logic [HW-1:0]     h_pos,
   input logic [VW-1:0]     v_pos,
   input logic              field_odd,
   input logic [ROW_W-1:0]  char_row,
   input logic [ADDR_W-1:0] row_addr,
   input logic [ADDR_W-1:0] byte_addr,
   input logic              rtc_pulse,
   input logic              rtc_flag
);
   localparam logic [HW-1:0] H_LAST_C = HW'(H_TOTAL - 8);
   localparam logic [HW-1:0] HALF_C   = HW'(H_HALF);
   localparam logic [HW-1:0] SYNC_C   = HW'(HSYNC_END);
   localparam logic [HW-1:0] LOAD_C   = HW'(H_ADDR_LOAD);
   localparam logic [VW-1:0] V_LAST_C = VW'(V_LAST);
   localparam logic [VW-1:0] RTC_C    = VW'(RTC_LINE);

   assert_h_step_R1: assert property (@(posedge clk) disable iff (rst)
      (step_en && h_pos != H_LAST_C) |=> h_pos == HW'($past(h_pos) + HW'(8)));

   assert_h_wrap_R1: assert property (@(posedge clk) disable iff (rst)
      (step_en && h_pos == H_LAST_C) |=> h_pos == '0);

   assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> ($stable(h_pos) && $stable(v_pos) && $stable(field_odd) && $stable(char_row)));

   assert_field_wrap_R2: assert property (@(posedge clk) disable iff (rst)
      (step_en && h_pos == H_LAST_C && v_pos == V_LAST_C)
      |=> (v_pos == '0 && field_odd != $past(field_odd)));

   assert_irq_point_R4: assert property (@(posedge clk) disable iff (rst)
      rtc_pulse |-> ($past(step_en) && $past(v_pos) == RTC_C &&
                     ($past(field_odd) ? $past(h_pos) == HALF_C : $past(h_pos) == '0)));

   assert_irq_single_R4: assert property (@(posedge clk) disable iff (rst)
      rtc_pulse |=> !rtc_pulse);

   generate
      if (IRQ_STICKY) begin : g_flag_chk
         assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
            rtc_pulse |-> rtc_flag);
      end
   endgenerate

   assert_row_frame_R6: assert property (@(posedge clk) disable iff (rst)
      (step_en && h_pos == SYNC_C && v_pos == V_LAST_C) |=> char_row == '0);

   assert_addr_load_R7: assert property (@(posedge clk) disable iff (rst)
      (step_en && h_pos == LOAD_C && v_pos == V_LAST_C)
      |=> (row_addr == $past(base_addr) && byte_addr == $past(base_addr)));
endmodule

bind raster_timer raster_timer_chk #(
   .H_TOTAL(H_TOTAL), .H_HALF(H_HALF), .HSYNC_END(HSYNC_END),
   .H_ADDR_LOAD(H_ADDR_LOAD), .V_LAST(V_LAST), .RTC_LINE(RTC_LINE),
   .ADDR_W(ADDR_W), .ROW_W(ROW_W), .IRQ_STICKY(IRQ_STICKY),
   .HW(HW), .VW(VW)
) u_chk (
   .clk(clk), .rst(rst), .step_en(step_en), .irq_clr(irq_clr),
   .base_addr(base_addr), .row_last(row_last), .h_pos(h_pos),
   .v_pos(v_pos), .field_odd(field_odd), .char_row(char_row),
   .row_addr(row_addr), .byte_addr(byte_addr),
   .rtc_pulse(rtc_pulse), .rtc_flag(rtc_flag)
);

// File: tb/raster_timer_test.sv
module raster_timer_test;
   localparam int STEPS    = 128;
   localparam int LINES    = 312;
   localparam int FIELD_CY = STEPS * LINES;
   localparam int SYNC_END = 832;
   localparam int RTC_LN   = 100;
   localparam int HALF     = 512;
   localparam int LOAD0    = 311 * STEPS + 896 / 8;
   localparam int S0       = RTC_LN * STEPS;
   localparam int P0       = S0 + 1;
   localparam int P1       = FIELD_CY + S0 + HALF / 8 + 1;
   localparam logic [14:0] B1 = 15'h1A00;
   localparam logic [14:0] B2 = 15'h2C40;
   localparam logic [14:0] B3 = 15'h0F10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        step_en = 1'b0;
   logic        irq_clr = 1'b0;
   logic [14:0] base_addr = B1;
   logic [3:0]  row_last = 4'd7;
   logic [9:0]  h_pos;
   logic [8:0]  v_pos;
   logic        field_odd;
   logic [3:0]  char_row;
   logic [14:0] row_addr;
   logic [14:0] byte_addr;
   logic        rtc_pulse;
   logic        rtc_flag;

   int checks = 0;
   int errors = 0;
   int k = 0;
   int phase = 0;
   bit flag_exp = 1'b0;
   bit run_chk = 1'b0;
   bit finished = 1'b0;
   int irq_q[$];

   raster_timer uut (
      .clk(clk), .rst(rst), .step_en(step_en), .irq_clr(irq_clr),
      .base_addr(base_addr), .row_last(row_last), .h_pos(h_pos),
      .v_pos(v_pos), .field_odd(field_odd), .char_row(char_row),
      .row_addr(row_addr), .byte_addr(byte_addr),
      .rtc_pulse(rtc_pulse), .rtc_flag(rtc_flag)
   );

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, k);
      end
   endtask

   task automatic push_irqs();
      irq_q.push_back(P0);
      irq_q.push_back(P1);
   endtask

   // reference edge counter and sticky flag model
   always @(posedge clk) begin
      if (rst) begin
         k = 0;
         flag_exp = 1'b0;
      end else begin
         if (irq_clr) flag_exp = 1'b0;
         if (step_en) begin
            k = k + 1;
            if (phase == 0 && (k == P0 || k == P1)) flag_exp = 1'b1;
         end
      end
   end

   // monitor: samples 5 ns after each rising edge
   always @(posedge clk) begin
      #5;
      if (run_chk && !rst) begin
         int line, hx, rh, passed, crow;
         logic [14:0] aexp;
         hx = (k % STEPS) * 8;
         line = (k / STEPS) % LINES;
         rh = (phase == 0) ? 8 : 10;
         check(int'(h_pos) == hx, "R1", int'(h_pos), hx);
         check(int'(v_pos) == line, "R2", int'(v_pos), line);
         check(int'(field_odd) == (k / FIELD_CY) % 2, "R2", int'(field_odd), (k / FIELD_CY) % 2);
         passed = (hx > SYNC_END) ? 1 : 0;
         crow = (line == LINES - 1 && passed == 1) ? 0 : (line + passed) % rh;
         check(int'(char_row) == crow, "R6", int'(char_row), crow);
         if (k <= LOAD0) aexp = B1;
         else if (k <= LOAD0 + FIELD_CY) aexp = B2;
         else aexp = B3;
         check(row_addr == aexp && byte_addr == aexp, "R7", int'(row_addr), int'(aexp));
         check(rtc_flag == flag_exp, "R5", int'(rtc_flag), int'(flag_exp));
         if (k == FIELD_CY)
            check(v_pos == 9'd0 && field_odd == 1'b1, "R9", int'(v_pos), 0);
         if (rtc_pulse) begin
            if (irq_q.size() == 0) begin
               check(1'b0, "R4 spurious", k, -1);
            end else begin
               int e;
               e = irq_q.pop_front();
               check(k == e, "R3 R4", k, e);
            end
         end
      end
   end

   task automatic do_reset(input logic [3:0] rl);
      @(negedge clk);
      run_chk = 1'b0;
      rst = 1'b1;
      step_en = 1'b1;
      irq_clr = 1'b0;
      base_addr = B1;
      row_last = rl;
      repeat (3) @(negedge clk);
      check(h_pos == '0 && v_pos == '0 && !field_odd && char_row == '0, "R8", int'(h_pos), 0);
      check(!rtc_pulse && !rtc_flag, "R8", int'(rtc_flag), 0);
      check(row_addr == B1 && byte_addr == B1, "R8", int'(row_addr), int'(B1));
      rst = 1'b0;
      run_chk = 1'b1;
   endtask

   initial begin
      int stall_cnt;
      bit clr_done;
      stall_cnt = 0;
      clr_done = 1'b0;
      phase = 0;
      do_reset(4'd7);
      push_irqs();
      while (k < 2 * FIELD_CY + 300) begin
         @(negedge clk);
         irq_clr = 1'b0;
         step_en = 1'b1;
         if (k == 1000) base_addr = B2;
         if (k == 50000) base_addr = B3;
         if (k == S0 && stall_cnt < 4) begin
            step_en = 1'b0;
            stall_cnt++;
         end
         if (k == S0 + 10 && !clr_done) begin
            irq_clr = 1'b1;
            clr_done = 1'b1;
         end
      end
      @(negedge clk);
      check(irq_q.size() == 0, "R4 count", irq_q.size(), 0);
      phase = 1;
      do_reset(4'd9);
      while (k < 2600) @(negedge clk);
      run_chk = 1'b0;
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule